// File: doc/BRIEF.md
# Modulated Numerically Controlled Oscillator

This block is a phase-accumulator oscillator for a synthesizer datapath. A 32-bit phase register advances on every enabled clock by a tuning step, and the top bits of the phase, after a phase offset is added, select a signed entry of a sine lookup. The lookup result is then multiplied by an amplitude scale. The block drives the resulting signed 16-bit sample to a downstream converter. It also drives a 1-bit square wave taken from the top bit of the same modulated phase, for systems with no converter.

Three per-sample modulation inputs sit on the datapath. A frequency offset is added to the base tuning word, which gives FM. A phase offset is added to the phase on its way to the lookup and is never written back, which gives PM. An unsigned fixed-point factor multiplies the looked-up sample, which gives AM. The output is fully registered. A valid flag marks the samples that come from enabled input cycles.

Top module: `nco_mod_top`

## Requirements
- R1: On each clock with `en` high the phase register becomes (phase + `base_fcw_i` + `fm_ofs_i`) mod 2^32, with no saturation. The FM offset is two's complement, so a negative offset is written as its 32-bit wrap value.
- R2: On a clock with `en` low the phase register keeps its value, and no valid sample results from that cycle.
- R3: The lookup phase for a cycle is (phase + `pm_ofs_i`) mod 2^32, using the phase register value from before that cycle's update. The phase offset is never accumulated, so it affects only the sample of its own cycle.
- R4: Bits [31:22] of the lookup phase form an address a in 0..1023. The table value is round-half-away-from-zero(32767 * sin(2*pi*a/1024)).
- R5: `am_scale_i` is unsigned with 15 fractional bits, so 0x8000 means unity. The sample is floor(table value * scale / 2^15), clamped to the range -32768..32767.
- R6: `square_o` equals bit 31 of the lookup phase and has the same alignment as the sample.
- R7: Inputs sampled at a rising edge produce `sample_o`, `square_o` and `valid_o`=1 after the second rising edge that follows it. This is three register stages.
- R8: While `valid_o` is low, `sample_o` and `square_o` keep the values of the last valid sample.
- R9: Synchronous reset (`rst` high at a rising edge) clears the phase register, `valid_o`, `sample_o` and `square_o` to zero. The first sample after reset is therefore the sine of the phase offset alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance phase and produce a sample this cycle |
| base_fcw_i | input | 32 | Base tuning step |
| fm_ofs_i | input | 32 | Per-sample frequency offset, two's complement |
| pm_ofs_i | input | 32 | Per-sample phase offset |
| am_scale_i | input | 16 | Amplitude factor, unsigned, 15 fractional bits |
| sample_o | output | 16 | Signed sine sample |
| square_o | output | 1 | Top bit of the modulated phase |
| valid_o | output | 1 | Sample and square are from an enabled cycle |

## Verification
Frequency and phase modulation act in the same cycle, but they reach the output by different routes. The FM offset changes only the phase seen by later samples. The PM offset changes only the present one. The bench changes both offsets, the scale and the enable on every cycle of a long run. It also has a directed case in which a large phase offset in one cycle is followed by a zero offset in the next. In every case a software model that advances its phase by base plus FM and adds PM only at the lookup predicts each sample. A phase offset leaking into the stored phase, or an FM offset applied a cycle early, then shows up as a wrong sample value three edges later.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Signed table code for point idx of a 2**addr_w point sine period,
   // full scale 2**(samp_w-1)-1, rounded half away from zero.
   function automatic int sine_code(input int idx, input int addr_w, input int samp_w);
      real full_scale;
      real angle;
      real raw;
      full_scale = real'((1 << (samp_w - 1)) - 1);
      angle      = 2.0 * 3.14159265358979323846 * real'(idx) / real'(1 << addr_w);
      raw        = full_scale * $sin(angle);
      if (raw >= 0.0)
         return $rtoi(raw + 0.5);
      else
         return -$rtoi(0.5 - raw);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
// Stage 1: phase register and phase-offset adder, with a side channel
// that carries the amplitude factor along with the address.
module nco_phase_acc #(
   parameter int ACC_W  = 32,
   parameter int ADDR_W = 10,
   parameter int SIDE_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [ACC_W-1:0]  base_i,
   input  logic [ACC_W-1:0]  fm_i,
   input  logic [ACC_W-1:0]  pm_i,
   input  logic [SIDE_W-1:0] side_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              msb_o,
   output logic [SIDE_W-1:0] side_o,
   output logic              vld_o
);

   localparam int TOP = ACC_W - 1;

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] step;
   logic [ACC_W-1:0] look_ph;

   // Effective tuning step: base plus FM, wrapping.
   assign step    = base_i + fm_i;
   // Phase seen by the lookup: stored phase plus PM, never written back.
   assign look_ph = acc_q + pm_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         addr_o <= '0;
         msb_o  <= 1'b0;
         side_o <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= en;
         if (en) begin
            acc_q  <= acc_q + step;
            addr_o <= look_ph[TOP -: ADDR_W];
            msb_o  <= look_ph[TOP];
            side_o <= side_i;
         end
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/nco_sine_lut.sv
// Stage 2: phase-to-amplitude conversion. QUARTER selects a folded
// quarter-period table or a direct full-period table.
module nco_sine_lut #(
   parameter int ADDR_W  = 10,
   parameter int SAMP_W  = 16,
   parameter int SIDE_W  = 16,
   parameter bit QUARTER = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic [ADDR_W-1:0]        addr_i,
   input  logic                     msb_i,
   input  logic [SIDE_W-1:0]        side_i,
   output logic                     vld_o,
   output logic signed [SAMP_W-1:0] sine_o,
   output logic                     msb_o,
   output logic [SIDE_W-1:0]        side_o
);

   localparam int POINTS = 1 << ADDR_W;
   localparam int QN     = POINTS / 4;
   localparam int LOW_W  = ADDR_W - 2;
   localparam int IDX_W  = ADDR_W - 1;

   logic signed [SAMP_W-1:0] lut_val;

   generate
      if (QUARTER) begin : g_quarter
         logic signed [SAMP_W-1:0] qtab [0:QN];
         logic [1:0]               quad;
         logic [LOW_W-1:0]         low;
         logic [IDX_W-1:0]         idx;
         logic signed [SAMP_W-1:0] mag;

         for (genvar k = 0; k <= QN; k++) begin : g_ent
            localparam int CODE = nco_pkg::sine_code(k, ADDR_W, SAMP_W);
            assign qtab[k] = SAMP_W'(CODE);
         end

         assign quad = addr_i[ADDR_W-1 -: 2];
         assign low  = addr_i[LOW_W-1:0];

         always_comb begin
            // Odd quadrants run the quarter table backwards.
            if (quad[0])
               idx = IDX_W'(QN) - {1'b0, low};
            else
               idx = {1'b0, low};
            mag = qtab[idx];
            // Second half of the period is the negated first half.
            lut_val = quad[1] ? -mag : mag;
         end
      end else begin : g_full
         logic signed [SAMP_W-1:0] ftab [0:POINTS-1];

         for (genvar k = 0; k < POINTS; k++) begin : g_ent
            localparam int CODE = nco_pkg::sine_code(k, ADDR_W, SAMP_W);
            assign ftab[k] = SAMP_W'(CODE);
         end

         always_comb lut_val = ftab[addr_i];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o  <= 1'b0;
         sine_o <= '0;
         msb_o  <= 1'b0;
         side_o <= '0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            sine_o <= lut_val;
            msb_o  <= msb_i;
            side_o <= side_i;
         end
      end
   end

endmodule

// File: rtl/nco_am_scale.sv
// Stage 3: amplitude scaling by an unsigned fixed-point factor and
// reduction back to the sample width.
module nco_am_scale #(
   parameter int SAMP_W     = 16,
   parameter int SCALE_W    = 16,
   parameter int SCALE_FRAC = 15,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic signed [SAMP_W-1:0] sine_i,
   input  logic [SCALE_W-1:0]       scale_i,
   input  logic                     msb_i,
   output logic                     vld_o,
   output logic signed [SAMP_W-1:0] sample_o,
   output logic                     msb_o
);

   localparam int PROD_W = SAMP_W + SCALE_W + 1;
   localparam logic signed [PROD_W-1:0] HI_LIM = PROD_W'((64'sd1 <<< (SAMP_W - 1)) - 1);
   localparam logic signed [PROD_W-1:0] LO_LIM = -HI_LIM - PROD_W'(1);

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] shifted;
   logic signed [SAMP_W-1:0] reduced;

   // Scale is unsigned: widen with a zero so it multiplies as positive.
   assign prod    = PROD_W'(sine_i) * PROD_W'($signed({1'b0, scale_i}));
   assign shifted = prod >>> SCALE_FRAC;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (shifted > HI_LIM)
               reduced = HI_LIM[SAMP_W-1:0];
            else if (shifted < LO_LIM)
               reduced = LO_LIM[SAMP_W-1:0];
            else
               reduced = shifted[SAMP_W-1:0];
         end
      end else begin : g_wrap
         assign reduced = shifted[SAMP_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o    <= 1'b0;
         sample_o <= '0;
         msb_o    <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            sample_o <= reduced;
            msb_o    <= msb_i;
         end
      end
   end

endmodule

// File: rtl/nco_mod_top.sv
// Modulated oscillator: phase register -> sine lookup -> amplitude scale.
module nco_mod_top #(
   parameter int ACC_W      = 32,
   parameter int ADDR_W     = 10,
   parameter int SAMP_W     = 16,
   parameter int SCALE_W    = 16,
   parameter int SCALE_FRAC = 15,
   parameter bit QUARTER    = 1'b1,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     en,
   input  logic [ACC_W-1:0]         base_fcw_i,
   input  logic [ACC_W-1:0]         fm_ofs_i,
   input  logic [ACC_W-1:0]         pm_ofs_i,
   input  logic [SCALE_W-1:0]       am_scale_i,
   output logic signed [SAMP_W-1:0] sample_o,
   output logic                     square_o,
   output logic                     valid_o
);

   // Elaboration-time parameter checks.
   generate
      if (ADDR_W < 3 || ADDR_W > 16) begin : g_bad_addr
         $error("nco_mod_top: ADDR_W must lie in 3..16");
      end
      if (ADDR_W > ACC_W) begin : g_bad_acc
         $error("nco_mod_top: ADDR_W must not exceed ACC_W");
      end
      if (SAMP_W < 4 || SAMP_W > 30) begin : g_bad_samp
         $error("nco_mod_top: SAMP_W must lie in 4..30");
      end
      if (SCALE_FRAC < 1 || SCALE_FRAC > SCALE_W) begin : g_bad_frac
         $error("nco_mod_top: SCALE_FRAC must lie in 1..SCALE_W");
      end
   endgenerate

   logic [ACC_W-1:0]         acc_q;
   logic [ADDR_W-1:0]        s1_addr;
   logic                     s1_msb;
   logic [SCALE_W-1:0]       s1_scale;
   logic                     s1_vld;
   logic signed [SAMP_W-1:0] s2_sine;
   logic                     s2_msb;
   logic [SCALE_W-1:0]       s2_scale;
   logic                     s2_vld;

   nco_phase_acc #(
      .ACC_W  (ACC_W),
      .ADDR_W (ADDR_W),
      .SIDE_W (SCALE_W)
   ) u_phase (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .base_i (base_fcw_i),
      .fm_i   (fm_ofs_i),
      .pm_i   (pm_ofs_i),
      .side_i (am_scale_i),
      .acc_o  (acc_q),
      .addr_o (s1_addr),
      .msb_o  (s1_msb),
      .side_o (s1_scale),
      .vld_o  (s1_vld)
   );

   nco_sine_lut #(
      .ADDR_W  (ADDR_W),
      .SAMP_W  (SAMP_W),
      .SIDE_W  (SCALE_W),
      .QUARTER (QUARTER)
   ) u_lut (
      .clk    (clk),
      .rst    (rst),
      .vld_i  (s1_vld),
      .addr_i (s1_addr),
      .msb_i  (s1_msb),
      .side_i (s1_scale),
      .vld_o  (s2_vld),
      .sine_o (s2_sine),
      .msb_o  (s2_msb),
      .side_o (s2_scale)
   );

   nco_am_scale #(
      .SAMP_W     (SAMP_W),
      .SCALE_W    (SCALE_W),
      .SCALE_FRAC (SCALE_FRAC),
      .SATURATE   (SATURATE)
   ) u_amp (
      .clk      (clk),
      .rst      (rst),
      .vld_i    (s2_vld),
      .sine_i   (s2_sine),
      .scale_i  (s2_scale),
      .msb_i    (s2_msb),
      .vld_o    (valid_o),
      .sample_o (sample_o),
      .msb_o    (square_o)
   );

endmodule

// File: rtl/nco_mod_chk.sv
// Property checker attached to the oscillator top.
module nco_mod_chk #(
   parameter int ACC_W  = 32,
   parameter int SAMP_W = 16
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     en,
   input logic [ACC_W-1:0]         acc_q,
   input logic signed [SAMP_W-1:0] sample_o,
   input logic                     square_o,
   input logic                     valid_o
);

   // Independent record of the enable over the last three edges.
   logic en_d1, en_d2, en_d3;
   always_ff @(posedge clk) begin
      if (rst) begin
         en_d1 <= 1'b0;
         en_d2 <= 1'b0;
         en_d3 <= 1'b0;
      end else begin
         en_d1 <= en;
         en_d2 <= en_d1;
         en_d3 <= en_d2;
      end
   end

   // R2
   acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(acc_q));

   // R7
   valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o == en_d3);

   // R8
   out_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!valid_o && !$past(rst)) |-> ($stable(sample_o) && $stable(square_o)));

   // R6
   square_neg_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && square_o) |-> (sample_o <= 0));

   // R6
   square_pos_chk: assert property (@(posedge clk) disable iff (rst)
      (valid_o && !square_o) |-> (sample_o >= 0));

   // R9
   reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!valid_o && acc_q == '0 && sample_o == '0 && !square_o));

endmodule

bind nco_mod_top nco_mod_chk #(
   .ACC_W  (ACC_W),
   .SAMP_W (SAMP_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .en       (en),
   .acc_q    (acc_q),
   .sample_o (sample_o),
   .square_o (square_o),
   .valid_o  (valid_o)
);

// File: tb/tb_nco_mod_top.sv
`timescale 1ns/1ps
module tb_nco_mod_top;

   localparam int NS = 48;
   localparam int NV = 8;

   // {base, fm, pm, scale}
   localparam logic [111:0] VECS [NV] = '{
      {32'h0100_0000, 32'h0000_0000, 32'h0000_0000, 16'h8000},
      {32'h1000_0000, 32'hF000_0000, 32'h4000_0000, 16'h8000},
      {32'h8000_0000, 32'h4000_0000, 32'hC000_0000, 16'hFFFF},
      {32'h0800_0000, 32'h0040_0000, 32'h2000_0000, 16'h4000},
      {32'hFFFF_FFFF, 32'h0000_0001, 32'h1234_5678, 16'h0000},
      {32'h3000_0000, 32'h1000_0000, 32'h4000_0000, 16'hFFFF},
      {32'h00C0_0000, 32'h7FC0_0000, 32'h8040_0000, 16'h6000},
      {32'h1555_5555, 32'h0AAA_AAAB, 32'h0000_0000, 16'h7FFF}
   };

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               en = 1'b0;
   logic [31:0]        base = '0;
   logic [31:0]        fm = '0;
   logic [31:0]        pm = '0;
   logic [15:0]        scale = '0;
   logic signed [15:0] sample_o;
   logic               square_o;
   logic               valid_o;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   nco_mod_top dut (
      .clk        (clk),
      .rst        (rst),
      .en         (en),
      .base_fcw_i (base),
      .fm_ofs_i   (fm),
      .pm_ofs_i   (pm),
      .am_scale_i (scale),
      .sample_o   (sample_o),
      .square_o   (square_o),
      .valid_o    (valid_o)
   );

   // Sample predicted from the requirements (R4, R5).
   function automatic logic signed [15:0] model(input logic [31:0] ph, input logic [15:0] sc);
      int     a;
      real    x;
      longint s;
      longint p;
      a = int'(ph[31:22]);
      x = 32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(a) / 1024.0);
      s = (x >= 0.0) ? longint'($rtoi(x + 0.5)) : -longint'($rtoi(0.5 - x));
      p = s * longint'({48'd0, sc});
      p = p >>> 15;
      if (p > 32767) p = 32767;
      if (p < -32768) p = -32768;
      return 16'(p);
   endfunction

   task automatic exp_check(input string req, input logic [31:0] ph, input logic [15:0] sc);
      logic signed [15:0] e;
      e = model(ph, sc);
      checks++;
      if (valid_o !== 1'b1 || sample_o !== e || square_o !== ph[31]) begin
         fails++;
         $display("FAIL %s: valid=%0b sample=%0d square=%0b expected valid=1 sample=%0d square=%0b",
                  req, valid_o, sample_o, square_o, e, ph[31]);
      end
   endtask

   task automatic idle_check(input string req, input logic signed [15:0] hs, input logic hq);
      checks++;
      if (valid_o !== 1'b0 || sample_o !== hs || square_o !== hq) begin
         fails++;
         $display("FAIL %s: valid=%0b sample=%0d square=%0b expected valid=0 sample=%0d square=%0b",
                  req, valid_o, sample_o, square_o, hs, hq);
      end
   endtask

   // Ends at a negedge with rst low, ready for the first input cycle.
   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      en  = 1'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0]        ph_q [0:63];
      logic [15:0]        sc_q [0:63];
      bit                 en_q [0:63];
      logic [31:0]        macc;
      logic [31:0]        lcg;
      logic signed [15:0] last_s;
      logic               last_q;

      // R9: reset state at the ports.
      do_reset();
      idle_check("R9 reset state", 16'sd0, 1'b0);

      // Table of vectors: two enabled cycles after reset, then a hold.
      for (int v = 0; v < NV; v++) begin
         logic [31:0] vb, vf, vp;
         logic [15:0] vs;
         {vb, vf, vp, vs} = VECS[v];
         do_reset();
         base = vb; fm = vf; pm = vp; scale = vs; en = 1'b1;   // sampled at E0
         @(negedge clk);                                       // sampled at E1
         @(negedge clk);
         en = 1'b0;
         @(negedge clk);
         // R9 R3 R4 R5 R7: first sample after reset uses the phase offset only
         exp_check("R9 R7 first sample", vp, vs);
         @(negedge clk);
         // R1: second sample uses phase base+fm (mod 2^32) plus pm
         exp_check("R1 R5 second sample", vb + vf + vp, vs);
         @(negedge clk);
         // R8: output held once valid drops
         idle_check("R8 hold after vector", model(vb + vf + vp, vs), vp[31] ^ 1'b0 ? (vb + vf + vp) >> 31 : (vb + vf + vp) >> 31);
      end

      // R3: phase offset of one cycle must not stay in the phase register.
      do_reset();
      base = 32'h0500_0000; fm = 32'h0000_0000; pm = 32'h4000_0000; scale = 16'h8000; en = 1'b1;
      @(negedge clk);
      pm = 32'h0000_0000;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      exp_check("R3 offset not stored", 32'h0500_0000, 16'h8000);

      // R2 R8: disabled cycles keep the phase and the output.
      do_reset();
      base = 32'h0A00_0000; fm = 32'h0010_0000; pm = 32'h0100_0000; scale = 16'h8000; en = 1'b1;
      @(negedge clk);
      en = 1'b0; base = 32'hDEAD_BEEF; fm = 32'h1234_5678; pm = 32'h7777_7777; scale = 16'h1111;
      @(negedge clk);
      @(negedge clk);
      exp_check("R7 sample before gap", 32'h0100_0000, 16'h8000);
      @(negedge clk);
      idle_check("R2 R8 gap holds output", model(32'h0100_0000, 16'h8000), 1'b0);
      base = 32'h5555_0000; fm = 32'h0000_0000; pm = 32'h0100_0000; scale = 16'h8000; en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      exp_check("R2 phase unchanged by gap", 32'h0A10_0000 + 32'h0100_0000, 16'h8000);

      // R1 R3 R5 R6 R7 R8: FM, PM, AM and enable all changing per cycle.
      do_reset();
      macc = '0; lcg = 32'h1357_9BDF; last_s = '0; last_q = 1'b0;
      for (int i = 0; i < NS + 3; i++) begin
         if (i >= 3) begin
            if (en_q[i-3]) begin
               exp_check("R1 R3 R6 stream sample", ph_q[i-3], sc_q[i-3]);
               last_s = model(ph_q[i-3], sc_q[i-3]);
               last_q = ph_q[i-3][31];
            end else begin
               idle_check("R8 stream idle", last_s, last_q);
            end
         end
         if (i < NS) begin
            lcg   = lcg * 32'd1664525 + 32'd1013904223;
            en    = (i % 7) != 5;
            base  = {4'h0, lcg[31:4]};
            lcg   = lcg * 32'd1664525 + 32'd1013904223;
            fm    = lcg;
            lcg   = lcg * 32'd1664525 + 32'd1013904223;
            pm    = lcg;
            lcg   = lcg * 32'd1664525 + 32'd1013904223;
            scale = lcg[31:16];
            ph_q[i] = macc + pm;
            sc_q[i] = scale;
            en_q[i] = en;
            if (en) macc = macc + base + fm;
         end else begin
            en = 1'b0;
         end
         @(negedge clk);
      end

      // R9: reset in the middle of use restarts the phase at zero.
      do_reset();
      base = 32'h7777_0000; fm = 32'h0000_0000; pm = 32'h4000_0000; scale = 16'h8000; en = 1'b1;
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      @(negedge clk);
      exp_check("R9 restart after reset", 32'h4000_0000, 16'h8000);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule